// File: doc/BRIEF.md
# Muon MIP and Isolation Tagger

The tagger gives each of eight muon candidates two calorimeter tags within a single pipelined pass. Every candidate arrives with an 8-bit phi coordinate, a 6-bit eta coordinate and a 3-bit quality code. Each candidate has its own pair of writable lookup tables. The eta table turns the eta coordinate into an eta bin, and the phi table turns the phi coordinate into a phi bin. Together the two bins pick one of 252 calorimeter regions. The tagger reads that region's bit from a minimum-ionizing map and from a quiet-region map, both presented in the same cycle as the muons. The result is a MIP flag and an isolation flag for every muon.

The tagger accepts one new event on every clock and returns its flags two cycles later under an output strobe. The table contents are loaded through a small write port, and this is done while no events are flowing. A candidate with a zero quality code, or one whose tables point outside the 14 x 18 region grid, gets no tags.

Top module: `mit_tagger`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and all sixteen flag bits are 0 until an event has passed through the pipeline.
- R2: An event presented with `in_valid` high shows up with `out_valid` high exactly two rising edges later. Back-to-back events come out on consecutive cycles in the order they went in.
- R3: For a tagged muon, `out_mip[m]` equals bit `idx` of `mip_map`, where idx is the region index of R5.
- R4: For a tagged muon, `out_iso[m]` equals bit `idx` of `quiet_map`, so it is 1 only when that region is quiet.
- R5: Muon m's eta bin e is its eta table entry at address `mu_eta[m]` (64 entries), and its phi bin p is its phi table entry at address `mu_phi[m]` (256 entries). Both entries are 5 bits wide. The region index is idx = e*18 + p.
- R6: If e >= 14 or p >= 18, both flags of that muon are 0.
- R7: If a muon's 3-bit quality code `mu_qual[3m+2:3m]` is 0, both of its flags are 0.
- R8: When `tbl_we` is high at a rising edge, it writes `tbl_data` into the table of muon `tbl_mu`. `tbl_kind` = 0 selects the eta table, addressed by `tbl_addr[5:0]`, and `tbl_kind` = 1 selects the phi table, addressed by `tbl_addr[7:0]`. The write changes only that entry of that muon and applies to events presented after the edge.
- R9: Whenever `out_valid` is 0, `out_mip` and `out_iso` are all 0.
- R10: Table writes are issued only while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Event present on the muon and map inputs |
| mu_eta | input | 48 | Eta coordinate, 6 bits per muon, muon m at [6m+5:6m] |
| mu_phi | input | 64 | Phi coordinate, 8 bits per muon, muon m at [8m+7:8m] |
| mu_qual | input | 24 | Quality code, 3 bits per muon, 0 means no candidate |
| mip_map | input | 252 | Minimum-ionizing bit per calorimeter region |
| quiet_map | input | 252 | Quiet bit per calorimeter region |
| tbl_we | input | 1 | Table write strobe |
| tbl_kind | input | 1 | 0 = eta table, 1 = phi table |
| tbl_mu | input | 3 | Muon whose table is written |
| tbl_addr | input | 8 | Table entry address |
| tbl_data | input | 5 | Bin value written |
| out_valid | output | 1 | Flags valid |
| out_mip | output | 8 | MIP flag per muon |
| out_iso | output | 8 | Isolation flag per muon |

## Verification
Each muon's tables are loaded with a different offset pattern, so a muon that reads another muon's table or lands on the wrong region produces a flag mismatch. The calorimeter maps are driven with four patterns: alternating MIP against every-third quiet, all-MIP/no-quiet, no-MIP/all-quiet, and every-fifth against alternating. Together these separate the MIP path from the isolation path and show a wrong eta or phi stride in the index. Events run back to back to show the two-cycle spacing. Directed events then target bins just past the grid edge, zero-quality candidates, and a single table rewrite that must flip only one muon's flags.

// File: rtl/mit_pkg.sv
package mit_pkg;
  localparam int DEF_N_MU     = 8;
  localparam int DEF_ETA_W    = 6;
  localparam int DEF_PHI_W    = 8;
  localparam int DEF_QUAL_W   = 3;
  localparam int DEF_BIN_W    = 5;
  localparam int DEF_ETA_BINS = 14;
  localparam int DEF_PHI_BINS = 18;

  // A bin pair is usable only when both bins fall inside the grid.
  function automatic logic bins_on_grid(input int eb, input int pb,
                                        input int eta_bins, input int phi_bins);
    return (eb < eta_bins) && (pb < phi_bins);
  endfunction

  // Row-major region number: eta bin selects the row of phi_bins regions.
  function automatic int region_of(input int eb, input int pb, input int phi_bins);
    return eb * phi_bins + pb;
  endfunction
endpackage

// File: rtl/mit_coord_lut.sv
module mit_coord_lut #(
  parameter int ETA_W = 6,
  parameter int PHI_W = 8,
  parameter int BIN_W = 5
) (
  input  logic             clk,
  input  logic             wr_eta,
  input  logic             wr_phi,
  input  logic [PHI_W-1:0] wr_addr,
  input  logic [BIN_W-1:0] wr_data,
  input  logic [ETA_W-1:0] eta_in,
  input  logic [PHI_W-1:0] phi_in,
  output logic [BIN_W-1:0] eta_bin,
  output logic [BIN_W-1:0] phi_bin
);
  localparam int ETA_DEPTH = 2 ** ETA_W;
  localparam int PHI_DEPTH = 2 ** PHI_W;

  logic [BIN_W-1:0] eta_mem [ETA_DEPTH];
  logic [BIN_W-1:0] phi_mem [PHI_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_eta) eta_mem[wr_addr[ETA_W-1:0]] <= wr_data;
    if (wr_phi) phi_mem[wr_addr] <= wr_data;
  end

  // Registered read: forms the first pipeline stage.
  always_ff @(posedge clk) begin
    eta_bin <= eta_mem[eta_in];
    phi_bin <= phi_mem[phi_in];
  end
endmodule

// File: rtl/mit_region_pick.sv
module mit_region_pick
  import mit_pkg::*;
#(
  parameter int BIN_W    = 5,
  parameter int ETA_BINS = 14,
  parameter int PHI_BINS = 18,
  localparam int N_REG   = ETA_BINS * PHI_BINS,
  localparam int IDX_W   = $clog2(N_REG)
) (
  input  logic [BIN_W-1:0] eta_bin,
  input  logic [BIN_W-1:0] phi_bin,
  input  logic             live,
  input  logic [N_REG-1:0] mip_map,
  input  logic [N_REG-1:0] quiet_map,
  output logic             on_grid,
  output logic             mip_hit,
  output logic             iso_hit
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    on_grid = bins_on_grid(int'(eta_bin), int'(phi_bin), ETA_BINS, PHI_BINS);
    idx     = '0;
    mip_hit = 1'b0;
    iso_hit = 1'b0;
    if (on_grid && live) begin
      idx     = IDX_W'(region_of(int'(eta_bin), int'(phi_bin), PHI_BINS));
      mip_hit = mip_map[idx];
      iso_hit = quiet_map[idx];
    end
  end
endmodule

// File: rtl/mit_tagger.sv
module mit_tagger
  import mit_pkg::*;
#(
  parameter int N_MU     = DEF_N_MU,
  parameter int ETA_W    = DEF_ETA_W,
  parameter int PHI_W    = DEF_PHI_W,
  parameter int QUAL_W   = DEF_QUAL_W,
  parameter int BIN_W    = DEF_BIN_W,
  parameter int ETA_BINS = DEF_ETA_BINS,
  parameter int PHI_BINS = DEF_PHI_BINS,
  localparam int N_REG   = ETA_BINS * PHI_BINS,
  localparam int MU_W    = $clog2(N_MU)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N_MU*ETA_W-1:0]   mu_eta,
  input  logic [N_MU*PHI_W-1:0]   mu_phi,
  input  logic [N_MU*QUAL_W-1:0]  mu_qual,
  input  logic [N_REG-1:0]        mip_map,
  input  logic [N_REG-1:0]        quiet_map,
  input  logic                    tbl_we,
  input  logic                    tbl_kind,
  input  logic [MU_W-1:0]         tbl_mu,
  input  logic [PHI_W-1:0]        tbl_addr,
  input  logic [BIN_W-1:0]        tbl_data,
  output logic                    out_valid,
  output logic [N_MU-1:0]         out_mip,
  output logic [N_MU-1:0]         out_iso
);
  // Stage 1 state (tables read, maps and qualities aligned)
  logic             s1_valid;
  logic [N_MU-1:0]  s1_live;
  logic [N_REG-1:0] s1_mip_map;
  logic [N_REG-1:0] s1_quiet_map;

  // Named per-muon events for the assertions
  logic [N_MU-1:0]  on_grid;
  logic [N_MU-1:0]  mip_hit;
  logic [N_MU-1:0]  iso_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
    s1_mip_map   <= mip_map;
    s1_quiet_map <= quiet_map;
  end

  generate
    for (genvar m = 0; m < N_MU; m++) begin : g_mu
      logic [BIN_W-1:0] eta_bin;
      logic [BIN_W-1:0] phi_bin;
      logic             sel_me;

      assign sel_me = tbl_we && (tbl_mu == MU_W'(m));

      mit_coord_lut #(.ETA_W(ETA_W), .PHI_W(PHI_W), .BIN_W(BIN_W)) u_lut (
        .clk     (clk),
        .wr_eta  (sel_me && !tbl_kind),
        .wr_phi  (sel_me &&  tbl_kind),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .eta_in  (mu_eta[m*ETA_W +: ETA_W]),
        .phi_in  (mu_phi[m*PHI_W +: PHI_W]),
        .eta_bin (eta_bin),
        .phi_bin (phi_bin)
      );

      always_ff @(posedge clk) begin
        s1_live[m] <= |mu_qual[m*QUAL_W +: QUAL_W];
      end

      mit_region_pick #(.BIN_W(BIN_W), .ETA_BINS(ETA_BINS), .PHI_BINS(PHI_BINS)) u_pick (
        .eta_bin   (eta_bin),
        .phi_bin   (phi_bin),
        .live      (s1_live[m]),
        .mip_map   (s1_mip_map),
        .quiet_map (s1_quiet_map),
        .on_grid   (on_grid[m]),
        .mip_hit   (mip_hit[m]),
        .iso_hit   (iso_hit[m])
      );

      // R6
      off_grid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !on_grid[m]) |=> (!out_mip[m] && !out_iso[m]));

      // R7
      empty_muon_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_live[m]) |=> (!out_mip[m] && !out_iso[m]));
    end
  endgenerate

  // Stage 2: flags register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mip   <= '0;
      out_iso   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_mip   <= s1_valid ? mip_hit : '0;
      out_iso   <= s1_valid ? iso_hit : '0;
    end
  end

  // R2
  stage_one_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  // R2
  stage_two_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  // R9
  idle_flags_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_mip == '0 && out_iso == '0));

  // R10
  write_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbl_we && in_valid));
endmodule

// File: tb/mit_tagger_test.sv
module mit_tagger_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 8;
  localparam int NR = 252;
  localparam int NVEC = 10;

  // {eta_base[5:0], phi_base[7:0], qual_mask[7:0], pattern[1:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {6'd0,  8'd0,   8'hFF, 2'd0},
    {6'd7,  8'd40,  8'hFF, 2'd1},
    {6'd21, 8'd99,  8'hFF, 2'd2},
    {6'd33, 8'd200, 8'hFF, 2'd3},
    {6'd50, 8'd17,  8'hA5, 2'd0},
    {6'd12, 8'd255, 8'h5A, 2'd3},
    {6'd63, 8'd128, 8'hFF, 2'd1},
    {6'd3,  8'd77,  8'hF0, 2'd2},
    {6'd44, 8'd150, 8'h0F, 2'd0},
    {6'd29, 8'd5,   8'hFF, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NM*6-1:0] mu_eta = '0;
  logic [NM*8-1:0] mu_phi = '0;
  logic [NM*3-1:0] mu_qual = '0;
  logic [NR-1:0] mip_map = '0;
  logic [NR-1:0] quiet_map = '0;
  logic tbl_we = 1'b0;
  logic tbl_kind = 1'b0;
  logic [2:0] tbl_mu = '0;
  logic [7:0] tbl_addr = '0;
  logic [4:0] tbl_data = '0;
  logic out_valid;
  logic [NM-1:0] out_mip;
  logic [NM-1:0] out_iso;

  int checks = 0;
  int fails = 0;

  logic [4:0] eta_tab [NM][64];
  logic [4:0] phi_tab [NM][256];

  always #(CLK_PERIOD/2) clk = ~clk;

  mit_tagger uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .mu_eta(mu_eta), .mu_phi(mu_phi), .mu_qual(mu_qual),
    .mip_map(mip_map), .quiet_map(quiet_map),
    .tbl_we(tbl_we), .tbl_kind(tbl_kind), .tbl_mu(tbl_mu),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_mip(out_mip), .out_iso(out_iso)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic map_bit(input int pat, input bit quiet, input int i);
    case (pat)
      0:       return quiet ? (i % 3 == 0) : (i % 2 == 1);
      1:       return !quiet;
      2:       return quiet;
      default: return quiet ? (i % 2 == 0) : (i % 5 == 0);
    endcase
  endfunction

  function automatic logic [5:0] eta_of(input logic [23:0] v, input int m);
    return 6'((int'(v[23:18]) + 5 * m) % 64);
  endfunction
  function automatic logic [7:0] phi_of(input logic [23:0] v, input int m);
    return 8'((int'(v[17:10]) + 37 * m) % 256);
  endfunction
  function automatic logic [2:0] qual_of(input logic [23:0] v, input int m);
    return v[2 + m] ? 3'(m % 7 + 1) : 3'd0;
  endfunction

  task automatic drive_vec(input logic [23:0] v);
    for (int m = 0; m < NM; m++) begin
      mu_eta[m*6 +: 6]  = eta_of(v, m);
      mu_phi[m*8 +: 8]  = phi_of(v, m);
      mu_qual[m*3 +: 3] = qual_of(v, m);
    end
    for (int i = 0; i < NR; i++) begin
      mip_map[i]   = map_bit(int'(v[1:0]), 1'b0, i);
      quiet_map[i] = map_bit(int'(v[1:0]), 1'b1, i);
    end
    in_valid = 1'b1;
  endtask

  // Bench model of R3..R7
  task automatic expect_vec(input logic [23:0] v, output logic [NM-1:0] em, output logic [NM-1:0] ei);
    for (int m = 0; m < NM; m++) begin
      int e, p, idx;
      e = int'(eta_tab[m][eta_of(v, m)]);
      p = int'(phi_tab[m][phi_of(v, m)]);
      em[m] = 1'b0;
      ei[m] = 1'b0;
      if (qual_of(v, m) != 0 && e < 14 && p < 18) begin
        idx = p + 18 * e;
        em[m] = map_bit(int'(v[1:0]), 1'b0, idx);
        ei[m] = map_bit(int'(v[1:0]), 1'b1, idx);
      end
    end
  endtask

  task automatic check_vec(input logic [23:0] v);
    logic [NM-1:0] em, ei;
    expect_vec(v, em, ei);
    chk("R2 out_valid", 32'(out_valid), 32'd1);
    chk("R3 R5 out_mip", 32'(out_mip), 32'(em));
    chk("R4 R5 out_iso", 32'(out_iso), 32'(ei));
  endtask

  // One event, flags read two edges later
  task automatic single(input logic [23:0] v);
    @(negedge clk); drive_vec(v);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); check_vec(v);
  endtask

  task automatic write_entry(input bit kind, input int mu, input int addr, input int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_kind = kind; tbl_mu = 3'(mu);
    tbl_addr = 8'(addr); tbl_data = 5'(data);
    if (kind) phi_tab[mu][addr] = 5'(data);
    else      eta_tab[mu][addr] = 5'(data);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 flags after reset", 32'({out_mip, out_iso}), 32'd0);

    // R8: load every table with a per-muon offset pattern
    for (int m = 0; m < NM; m++) begin
      for (int a = 0; a < 64; a++)  write_entry(1'b0, m, a, (a + m) % 16);
      for (int a = 0; a < 256; a++) write_entry(1'b1, m, a, (a + 3 * m) % 20);
    end
    @(negedge clk); tbl_we = 1'b0;

    // R2..R5: vector table streamed back to back
    for (int i = 0; i < NVEC + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check_vec(VEC[i-2]);
      if (i < NVEC) drive_vec(VEC[i]);
      else in_valid = 1'b0;
    end

    // R9: idle pipeline shows no flags
    @(negedge clk);
    chk("R9 idle valid", 32'(out_valid), 32'd0);
    chk("R9 idle flags", 32'({out_mip, out_iso}), 32'd0);

    // R6: muon 0 eta bin 14 with all-MIP map
    single({6'd14, 8'd0, 8'hFF, 2'd1});
    chk("R6 eta bin past grid", 32'(out_mip[0]), 32'd0);
    // R6: muon 0 phi bin 18 with all-quiet map
    single({6'd0, 8'd18, 8'hFF, 2'd2});
    chk("R6 phi bin past grid", 32'(out_iso[0]), 32'd0);
    // R6: last on-grid bins (13, 17) still tag
    single({6'd13, 8'd17, 8'hFF, 2'd1});
    chk("R6 last region tagged", 32'(out_mip[0]), 32'd1);

    // R7: no candidates at all with both maps full
    @(negedge clk); drive_vec({6'd0, 8'd0, 8'h00, 2'd1}); quiet_map = '1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk("R7 zero quality flags", 32'({out_mip, out_iso}), 32'd0);

    // R8: one phi entry of muon 3 moves it from region 36 to 37
    single({6'd0, 8'd0, 8'hFF, 2'd0});
    chk("R8 muon3 before write", 32'({out_mip[3], out_iso[3]}), 32'b01);
    write_entry(1'b1, 3, 111, 1);
    @(negedge clk); tbl_we = 1'b0;
    single({6'd0, 8'd0, 8'hFF, 2'd0});
    chk("R8 muon3 after write", 32'({out_mip[3], out_iso[3]}), 32'b10);

    // R1: reset in mid-flight drops the event
    @(negedge clk); drive_vec(VEC[1]);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears valid", 32'(out_valid), 32'd0);
    chk("R1 reset clears flags", 32'({out_mip, out_iso}), 32'd0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule